// File: doc/BRIEF.md
# SD Card Clock Generator with Stability Timer and Software Reset

This block derives the clock that drives an SD or MMC card from the controller's base clock. Software programs a 16-bit clock control word that holds a divisor byte, an internal-clock enable and a card-clock enable. Hardware sets a read-only "stable" flag once the internal clock has had time to settle. The card clock is released only when the internal clock is enabled, the stable flag is set and the card-clock enable is set. The intended sequence is to clear the word, write the divisor with the internal enable, poll until the stable flag rises, and then set the card-clock enable as well.

A divisor value S other than zero gives a card clock of base/(2·S), with equal high and low phases of S base cycles each. A value of zero passes the base clock straight through. If the divisor is rewritten while the card clock runs, the new value is applied only at the end of a low phase, so no phase is shortened. A separate software reset request clears the whole clock control word. It holds a busy flag for a fixed number of cycles, and the flag then clears itself.

Top module: `sd_card_clkgen`

## Requirements
- R1: The readback word carries the divisor in bits 15:8, the card-clock enable in bit 2, the stable flag in bit 1 and the internal enable in bit 0; bits 7:3 read as zero, and the whole word reads 0 after reset.
- R2: The stable flag rises exactly STABLE_CYC base cycles after the clock edge that captures a write setting the internal enable; software writes to bit 1 have no effect.
- R3: The stable flag reads 0 in the same cycle that the internal enable reads 0.
- R4: The card clock stays low unless the internal enable, the stable flag and the card-clock enable are all set; setting the card-clock enable before the stable flag rises gives no card-clock edges.
- R5: With divisor S in 1..255, the card clock is high for S base cycles and low for S base cycles.
- R6: With divisor 0 (PASS_THRU=1), the card clock follows the base clock, high while it is high and low while it is low.
- R7: A divisor change while the card clock runs takes effect at the end of a low phase; every complete phase afterwards lasts either the old or the new divisor, and only the new one once the pending low phase has ended.
- R8: A software reset request raises the busy flag at the capturing edge, holds it for RST_CYC cycles and then clears it; the clock control word reads 0 from that edge on.
- R9: Writes to the clock control word are ignored while busy is set, and also in the cycle of the reset request itself.
- R10: Clearing the card-clock enable in divided mode drives the card clock low by the next base-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the clock control word |
| ctl_wdata | input | 16 | Clock control write data |
| ctl_rdata | output | 16 | Clock control readback, including the stable flag |
| swreset_req | input | 1 | One-cycle request for a full software reset |
| swreset_busy | output | 1 | Self-clearing reset flag |
| card_clk | output | 1 | Gated and divided card clock |

## Verification
Two pairs of events can fall in the same cycle. The first is a software reset request and a clock control write; the bench drives both strobes in one cycle and also writes in the middle of the busy window, and the readback must stay zero (reset wins). The second is a divisor rewrite and the end of a divider phase. Random divisors are written at random points while the card clock runs. Each run of high or low samples is then measured and must match the old or the new divisor, never a shorter length.

// File: rtl/sdclk_pkg.sv
`timescale 1ns/1ps
package sdclk_pkg;
   localparam int CTRL_W     = 16;
   localparam int SEL_LSB    = 8;
   localparam int BIT_INT_EN = 0;
   localparam int BIT_STABLE = 1;
   localparam int BIT_SD_EN  = 2;
endpackage

// File: rtl/sdclk_stable_timer.sv
`timescale 1ns/1ps
module sdclk_stable_timer #(
   parameter int STABLE_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic int_en,
   output logic stable
);
   localparam int CW = $clog2(STABLE_CYC + 1);

   if (STABLE_CYC < 1) begin : g_bad_cyc
      $error("STABLE_CYC must be at least 1");
   end

   logic [CW-1:0] cnt;
   logic          st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         st_q <= 1'b0;
      end else if (!int_en) begin
         cnt  <= '0;
         st_q <= 1'b0;
      end else if (!st_q) begin
         if (cnt == CW'(STABLE_CYC - 1)) st_q <= 1'b1;
         else                            cnt  <= cnt + CW'(1);
      end
   end

   assign stable = st_q & int_en;

   // independent age counter used only by the check below
   logic [CW-1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         age <= '0;
      else if (!int_en)                   age <= '0;
      else if (age != CW'(STABLE_CYC))    age <= age + CW'(1);
   end

   p_stable_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stable) |-> age == CW'(STABLE_CYC));
   p_fresh_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_en) |-> !st_q);
endmodule

// File: rtl/sdclk_divider.sv
`timescale 1ns/1ps
module sdclk_divider #(
   parameter int SEL_W     = 8,
   parameter bit PASS_THRU = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gate_on,
   input  logic [SEL_W-1:0] sel,
   output logic             card_clk
);
   logic [SEL_W-1:0] act_sel;
   logic [SEL_W-1:0] cnt;
   logic             div_q;
   logic [SEL_W-1:0] eff_sel;

   assign eff_sel = (!PASS_THRU && sel == '0) ? SEL_W'(1) : sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_sel <= '0;
         cnt     <= '0;
         div_q   <= 1'b0;
      end else if (!gate_on || act_sel == '0) begin
         div_q   <= 1'b0;
         cnt     <= '0;
         act_sel <= eff_sel;
      end else if (cnt == act_sel - SEL_W'(1)) begin
         cnt <= '0;
         if (div_q) begin
            div_q <= 1'b0;
         end else begin
            act_sel <= eff_sel;
            div_q   <= (eff_sel != '0);
         end
      end else begin
         cnt <= cnt + SEL_W'(1);
      end
   end

   if (PASS_THRU) begin : g_pass
      logic pass_lo;
      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n) pass_lo <= 1'b0;
         else        pass_lo <= gate_on && (act_sel == '0);
      end
      assign card_clk = pass_lo ? clk : div_q;
   end else begin : g_div_only
      assign card_clk = div_q;
   end

   p_sel_at_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(act_sel) && $past(gate_on)) |-> !$past(div_q));
   p_off_is_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_on |=> !div_q);
endmodule

// File: rtl/sdclk_reset_seq.sv
`timescale 1ns/1ps
module sdclk_reset_seq #(
   parameter int RST_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic busy
);
   localparam int RW = $clog2(RST_CYC + 1);

   if (RST_CYC < 1) begin : g_bad_rst
      $error("RST_CYC must be at least 1");
   end

   logic [RW-1:0] rcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         rcnt <= '0;
      end else if (req) begin
         busy <= 1'b1;
         rcnt <= '0;
      end else if (busy) begin
         if (rcnt == RW'(RST_CYC - 1)) busy <= 1'b0;
         else                          rcnt <= rcnt + RW'(1);
      end
   end

   p_req_sets_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> busy);
   p_busy_from_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req));
endmodule

// File: rtl/sd_card_clkgen.sv
`timescale 1ns/1ps
module sd_card_clkgen #(
   parameter int SEL_W      = 8,
   parameter int STABLE_CYC = 16,
   parameter int RST_CYC    = 8,
   parameter bit PASS_THRU  = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ctl_wr,
   input  logic [sdclk_pkg::CTRL_W-1:0] ctl_wdata,
   output logic [sdclk_pkg::CTRL_W-1:0] ctl_rdata,
   input  logic                       swreset_req,
   output logic                       swreset_busy,
   output logic                       card_clk
);
   import sdclk_pkg::*;

   if (SEL_W < 1 || SEL_W > CTRL_W - SEL_LSB) begin : g_bad_sel
      $error("SEL_W must fit in the upper byte");
   end

   localparam logic [CTRL_W-1:0] USED_MASK =
      (CTRL_W'((1 << SEL_W) - 1) << SEL_LSB) |
      CTRL_W'(1 << BIT_SD_EN) | CTRL_W'(1 << BIT_INT_EN);

   logic [SEL_W-1:0] sel_r;
   logic             sd_en_r;
   logic             int_en_r;
   logic             stable;
   logic             gate_on;
   logic             unused_wbits;

   assign unused_wbits = ^(ctl_wdata & ~USED_MASK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_r    <= '0;
         sd_en_r  <= 1'b0;
         int_en_r <= 1'b0;
      end else if (swreset_req || swreset_busy) begin
         sel_r    <= '0;
         sd_en_r  <= 1'b0;
         int_en_r <= 1'b0;
      end else if (ctl_wr) begin
         sel_r    <= ctl_wdata[SEL_LSB +: SEL_W];
         sd_en_r  <= ctl_wdata[BIT_SD_EN];
         int_en_r <= ctl_wdata[BIT_INT_EN];
      end
   end

   sdclk_stable_timer #(.STABLE_CYC(STABLE_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .int_en(int_en_r), .stable(stable));

   sdclk_reset_seq #(.RST_CYC(RST_CYC)) u_rst (
      .clk(clk), .rst_n(rst_n), .req(swreset_req), .busy(swreset_busy));

   assign gate_on = int_en_r & sd_en_r & stable;

   sdclk_divider #(.SEL_W(SEL_W), .PASS_THRU(PASS_THRU)) u_div (
      .clk(clk), .rst_n(rst_n), .gate_on(gate_on), .sel(sel_r),
      .card_clk(card_clk));

   always_comb begin
      ctl_rdata                     = '0;
      ctl_rdata[SEL_LSB +: SEL_W]   = sel_r;
      ctl_rdata[BIT_SD_EN]          = sd_en_r;
      ctl_rdata[BIT_STABLE]         = stable;
      ctl_rdata[BIT_INT_EN]         = int_en_r;
   end

   p_busy_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      swreset_busy |-> ctl_rdata == '0);
   p_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (swreset_req && ctl_wr) |=> ctl_rdata == '0);
   p_stable_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_rdata[BIT_INT_EN] |-> !ctl_rdata[BIT_STABLE]);
endmodule

// File: tb/sd_card_clkgen_test.sv
`timescale 1ns/1ps
module sd_card_clkgen_test;
   localparam int STB = 16;
   localparam int RSC = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_wr = 1'b0;
   logic [15:0] ctl_wdata = '0;
   logic [15:0] ctl_rdata;
   logic        swreset_req = 1'b0;
   logic        swreset_busy;
   logic        card_clk;

   int n_checks = 0;
   int n_fail   = 0;
   int runs[8];
   bit done = 1'b0;

   always #10 clk = ~clk;

   sd_card_clkgen #(.SEL_W(8), .STABLE_CYC(STB), .RST_CYC(RSC), .PASS_THRU(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata), .swreset_req(swreset_req),
      .swreset_busy(swreset_busy), .card_clk(card_clk));

   function automatic logic [15:0] exp_word(input int sel, input bit sd,
                                            input bit st, input bit ie);
      return {8'(sel), 5'b0, sd, st & ie, ie};
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] d);
      @(negedge clk);
      ctl_wr = 1'b1; ctl_wdata = d;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic get_runs(input int n);
      logic prev;
      int   guard;
      prev = card_clk; guard = 0;
      while (card_clk == prev && guard < 400) begin @(negedge clk); guard++; end
      for (int i = 0; i < n; i++) begin
         logic cur;
         int   len;
         cur = card_clk; len = 0;
         while (card_clk == cur && len < 400) begin len++; @(negedge clk); end
         runs[i] = len;
      end
   endtask

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog expired, all requirements unchecked");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      int old_s, s;
      bit quiet;
      void'($urandom(32'd7719));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(ctl_rdata == 16'h0, "R1 reset readback", ctl_rdata, 0);
      check(swreset_busy == 1'b0, "R8 busy idle after reset", swreset_busy, 0);

      // R2/R4: enable everything at once with divisor 3 and bit 1 plus junk bits set
      s = 3;
      wr({8'(s), 8'hFF});
      check(ctl_rdata == exp_word(s, 1, 0, 1), "R1 R2 readback after write", ctl_rdata, exp_word(s, 1, 0, 1));
      quiet = 1'b1;
      for (int k = 1; k < STB; k++) begin
         @(negedge clk);
         if (card_clk) quiet = 1'b0;
      end
      check(ctl_rdata[1] == 1'b0, "R2 stable not yet", ctl_rdata[1], 0);
      check(quiet, "R4 no card clock before stable", card_clk, 0);
      @(negedge clk);
      check(ctl_rdata[1] == 1'b1, "R2 stable after delay", ctl_rdata[1], 1);

      // R5 divided clock
      get_runs(4);
      for (int i = 0; i < 4; i++)
         check(runs[i] == s, "R5 phase length", runs[i], s);

      // R7 random divisor changes while running
      old_s = s;
      for (int it = 0; it < 8; it++) begin
         s = $urandom_range(1, 7);
         repeat ($urandom_range(0, 9)) @(negedge clk);
         wr({8'(s), 8'h05});
         get_runs(6);
         for (int i = 0; i < 2; i++)
            check(runs[i] == s || runs[i] == old_s, "R7 no runt phase", runs[i], s);
         for (int i = 2; i < 6; i++)
            check(runs[i] == s, "R7 new divisor applied", runs[i], s);
         old_s = s;
      end

      // R6 pass-through
      wr(16'h0005);
      repeat (3 * 8) @(negedge clk);
      for (int i = 0; i < 4; i++) begin
         @(posedge clk); #5;
         check(card_clk == 1'b1, "R6 follows base high", card_clk, 1);
         @(negedge clk); #5;
         check(card_clk == 1'b0, "R6 follows base low", card_clk, 0);
      end
      wr(16'h0305);
      get_runs(4);
      for (int i = 0; i < 4; i++)
         check(runs[i] == 3, "R5 back from pass-through", runs[i], 3);

      // R10 card-clock enable removed
      wr(16'h0201);
      @(negedge clk);
      quiet = 1'b1;
      for (int k = 0; k < 10; k++) begin
         if (card_clk) quiet = 1'b0;
         @(negedge clk);
      end
      check(quiet, "R10 card clock low after disable", card_clk, 0);
      check(ctl_rdata == exp_word(2, 0, 1, 1), "R1 stable kept while sd off", ctl_rdata, exp_word(2, 0, 1, 1));

      // R3 internal enable cleared
      wr(16'h0200);
      check(ctl_rdata[1] == 1'b0, "R3 stable drops with enable", ctl_rdata[1], 0);
      check(ctl_rdata == exp_word(2, 0, 0, 0), "R3 readback", ctl_rdata, exp_word(2, 0, 0, 0));

      // R8 software reset
      wr(16'h0405);
      repeat (STB + 4) @(negedge clk);
      @(negedge clk); swreset_req = 1'b1;
      @(negedge clk); swreset_req = 1'b0;
      check(swreset_busy == 1'b1, "R8 busy set", swreset_busy, 1);
      check(ctl_rdata == 16'h0, "R8 word cleared", ctl_rdata, 0);
      for (int k = 1; k < RSC; k++) begin
         @(negedge clk);
         check(swreset_busy == 1'b1, "R8 busy held", swreset_busy, 1);
      end
      @(negedge clk);
      check(swreset_busy == 1'b0, "R8 busy self-clears", swreset_busy, 0);

      // R9 collision of write and reset request, then write during busy
      wr(16'h0101);
      @(negedge clk);
      swreset_req = 1'b1; ctl_wr = 1'b1; ctl_wdata = 16'h0507;
      @(negedge clk);
      swreset_req = 1'b0; ctl_wr = 1'b0;
      check(ctl_rdata == 16'h0, "R9 reset wins same cycle", ctl_rdata, 0);
      wr(16'h0305);
      check(ctl_rdata == 16'h0, "R9 write ignored while busy", ctl_rdata, 0);
      repeat (RSC + 2) @(negedge clk);
      check(swreset_busy == 1'b0 && ctl_rdata == 16'h0, "R9 word still clear", ctl_rdata, 0);
      check(card_clk == 1'b0, "R4 card clock idle after reset", card_clk, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule